// File: doc/BRIEF.md
# Outbound MMIO Window Decoder

This block takes a CPU-side MMIO address and works out whether it falls inside one of the configured outbound windows. For each request it reports a hit flag, the bus address to forward, and the partition number that owns the access. Windows are naturally aligned power-of-two regions that software sets up through a small register write port.

There are two kinds of window. There is a single 32-bit remapping window. It replaces the address bits above its size with a programmed value. It splits its span into 256 equal segments, and a 256-entry table gives the partition for each segment. There are also sixteen 64-bit windows. These pass the address through unchanged. Each one either reports one fixed partition for its whole range, or, in segmented mode, reports the segment index itself as the partition. When windows overlap, a fixed priority picks one. Lookups are pipelined with one register stage.

Top module: `mmio_outbound_decoder`

## Requirements
- R1: A request with `req_valid` high produces `rsp_valid` high exactly one clock later. A cycle with `req_valid` low produces `rsp_valid` low one clock later.
- R2: An address that no enabled window matches gives `rsp_hit`=0, `rsp_part`=0 and `rsp_addr`=0.
- R3: The 32-bit window matches when the address bits at and above its size log2 equal the same bits of its base. Base bits below the size are ignored. On a hit, `rsp_addr` takes the remap value's bits at and above the size and the address bits below it.
- R4: On a 32-bit window hit, the partition is the table entry indexed by the 8 address bits just below the window size (bits size-1 down to size-8).
- R5: A written size log2 is clamped. For the 32-bit window it is held to the range 28..32. For the 64-bit windows the minimum is 28 and the maximum is the address width.
- R6: On a 64-bit window hit, `rsp_addr` equals the request address unchanged.
- R7: A 64-bit window in non-segmented mode reports its configured partition for every address it covers.
- R8: A 64-bit window in segmented mode reports the address bits size-1 down to size-8 as the partition.
- R9: Among enabled 64-bit windows that match, the lowest-numbered one wins. Any 64-bit hit takes precedence over the 32-bit window.
- R10: After reset every window is disabled, so all lookups miss. A window with its enable bit cleared never matches.
- R11: Configuration encoding is as follows. `cfg_kind` 0 writes the 32-bit base. Kind 1 writes the 32-bit control. Kind 2 writes the 32-bit remap value. Kind 3 writes table entry `cfg_idx` with `cfg_data[7:0]`. Kind 4 writes the base of 64-bit window `cfg_idx`. Kind 5 writes the control of 64-bit window `cfg_idx`. Control word layout: bit 0 is enable, bit 1 is segmented mode (64-bit only), bits 7:2 are size log2, and bits 15:8 are the partition (64-bit only). A write is visible to a lookup in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Selects which register is written |
| cfg_idx | input | 8 | Table entry or 64-bit window number |
| cfg_data | input | 48 | Write data |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 48 | CPU-side address to decode |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Address matched an enabled window |
| rsp_addr | output | 48 | Translated bus address (0 on miss) |
| rsp_part | output | 8 | Partition number (0 on miss) |

## Verification
Every lookup result appears one rising edge after its request. The bench drives a request on a falling edge and reads the response fields on the next falling edge, which is half a cycle after the register stage has captured them. A configuration write lands on the rising edge that follows it, so each write sequence completes before the lookup that relies on it is issued. Overlap, clamp and disable cases are arranged so that a wrong priority, a wrong clamp or a wrong segment slice each change the partition or the address that the bench expects.

// File: rtl/mmio_dec_pkg.sv
// Shared definitions for the outbound MMIO window decoder.
// Assumes the control word layout is common to both window kinds.
package mmio_dec_pkg;

    typedef enum logic [2:0] {
        CFG_W32_BASE  = 3'd0,
        CFG_W32_CTRL  = 3'd1,
        CFG_W32_REMAP = 3'd2,
        CFG_W32_TABLE = 3'd3,
        CFG_W64_BASE  = 3'd4,
        CFG_W64_CTRL  = 3'd5
    } cfg_kind_e;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_SEG_BIT  = 1;
    localparam int CTRL_SIZE_LSB = 2;
    localparam int LOG2_W        = 6;
    localparam int CTRL_PART_LSB = 8;

    // Hold a written size log2 inside the legal range of a window kind.
    function automatic logic [LOG2_W-1:0] clamp_log2(input logic [LOG2_W-1:0] v,
                                                     input int lo, input int hi);
        if (int'(v) < lo) return LOG2_W'(lo);
        if (int'(v) > hi) return LOG2_W'(hi);
        return v;
    endfunction

endpackage

// File: rtl/mmio_win32_map.sv
// 32-bit remapping window: holds base, size, remap value, enable and the
// segment-to-partition table, and decodes one address combinationally.
// Assumes SEG_BITS <= MIN_LOG2 so the segment slice stays inside the address.
module mmio_win32_map
    import mmio_dec_pkg::*;
#(
    parameter int ADDR_W   = 48,
    parameter int SEG_BITS = 8,
    parameter int IDX_W    = 8,
    parameter int MIN_LOG2 = 28,
    parameter int MAX_LOG2 = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [2:0]          cfg_kind,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [ADDR_W-1:0]   cfg_data,
    input  logic [ADDR_W-1:0]   lk_addr,
    output logic                hit,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [SEG_BITS-1:0] part
);
    localparam int NUM_SEG = 1 << SEG_BITS;

    logic [ADDR_W-1:0]   base_q;
    logic [ADDR_W-1:0]   remap_q;
    logic                en_q;
    logic [LOG2_W-1:0]   size_q;
    logic [SEG_BITS-1:0] tbl_q [NUM_SEG];

    logic [ADDR_W-1:0]   mask;
    logic [LOG2_W-1:0]   shamt;
    logic [SEG_BITS-1:0] seg;

    // Window registers: base, remap value, enable and clamped size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            remap_q <= '0;
            en_q    <= 1'b0;
            size_q  <= LOG2_W'(MAX_LOG2);
        end else if (cfg_wr) begin
            case (cfg_kind_e'(cfg_kind))
                CFG_W32_BASE:  base_q  <= cfg_data;
                CFG_W32_REMAP: remap_q <= cfg_data;
                CFG_W32_CTRL: begin
                    en_q   <= cfg_data[CTRL_EN_BIT];
                    size_q <= clamp_log2(cfg_data[CTRL_SIZE_LSB +: LOG2_W], MIN_LOG2, MAX_LOG2);
                end
                default: ;
            endcase
        end
    end

    // Segment-to-partition table, one entry written per table command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SEG; i++) tbl_q[i] <= '0;
        end else if (cfg_wr && cfg_kind_e'(cfg_kind) == CFG_W32_TABLE) begin
            tbl_q[cfg_idx[SEG_BITS-1:0]] <= cfg_data[SEG_BITS-1:0];
        end
    end

    // Decode: match on bits above the size, pick segment, splice remap bits.
    always_comb begin
        mask     = {ADDR_W{1'b1}} << size_q;
        shamt    = size_q - LOG2_W'(SEG_BITS);
        seg      = SEG_BITS'(lk_addr >> shamt);
        hit      = en_q && (((lk_addr ^ base_q) & mask) == '0);
        part     = tbl_q[seg];
        bus_addr = (remap_q & mask) | (lk_addr & ~mask);
    end

    // R4: a table write is stored at the addressed entry.
    assert_table_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_kind == 3'(CFG_W32_TABLE))
        |=> (tbl_q[$past(cfg_idx[SEG_BITS-1:0])] == $past(cfg_data[SEG_BITS-1:0])));

    // R5: a control write leaves the size inside the legal range.
    assert_size_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_kind == 3'(CFG_W32_CTRL))
        |=> (int'(size_q) >= MIN_LOG2 && int'(size_q) <= MAX_LOG2));

endmodule

// File: rtl/mmio_win64_slot.sv
// One 64-bit pass-through window: holds base, size, enable, mode and a fixed
// partition, and reports a match and partition for one address.
// Assumes SEG_BITS <= MIN_LOG2 so the segment slice stays inside the address.
module mmio_win64_slot
    import mmio_dec_pkg::*;
#(
    parameter int ADDR_W   = 48,
    parameter int SEG_BITS = 8,
    parameter int IDX_W    = 8,
    parameter int MIN_LOG2 = 28,
    parameter int MAX_LOG2 = 48,
    parameter int SLOT     = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [2:0]          cfg_kind,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [ADDR_W-1:0]   cfg_data,
    input  logic [ADDR_W-1:0]   lk_addr,
    output logic                hit,
    output logic [SEG_BITS-1:0] part
);
    logic [ADDR_W-1:0]   base_q;
    logic                en_q;
    logic                segm_q;
    logic [LOG2_W-1:0]   size_q;
    logic [SEG_BITS-1:0] part_q;

    logic                sel;
    logic [ADDR_W-1:0]   mask;
    logic [LOG2_W-1:0]   shamt;
    logic [SEG_BITS-1:0] seg;

    assign sel = cfg_wr && (cfg_idx == IDX_W'(SLOT));

    // Window registers, written only when the index names this slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            en_q   <= 1'b0;
            segm_q <= 1'b0;
            size_q <= LOG2_W'(MIN_LOG2);
            part_q <= '0;
        end else if (sel) begin
            if (cfg_kind_e'(cfg_kind) == CFG_W64_BASE) base_q <= cfg_data;
            if (cfg_kind_e'(cfg_kind) == CFG_W64_CTRL) begin
                en_q   <= cfg_data[CTRL_EN_BIT];
                segm_q <= cfg_data[CTRL_SEG_BIT];
                size_q <= clamp_log2(cfg_data[CTRL_SIZE_LSB +: LOG2_W], MIN_LOG2, MAX_LOG2);
                part_q <= cfg_data[CTRL_PART_LSB +: SEG_BITS];
            end
        end
    end

    // Decode: match on bits above the size; partition is fixed or the segment.
    always_comb begin
        mask  = {ADDR_W{1'b1}} << size_q;
        shamt = size_q - LOG2_W'(SEG_BITS);
        seg   = SEG_BITS'(lk_addr >> shamt);
        hit   = en_q && (((lk_addr ^ base_q) & mask) == '0);
        part  = segm_q ? seg : part_q;
    end

    // R11: a control write for this slot sets the enable bit it carries.
    assert_ctrl_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cfg_kind == 3'(CFG_W64_CTRL)) |=> (en_q == $past(cfg_data[CTRL_EN_BIT])));

    // R5: a control write never leaves the size below the floor.
    assert_size_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cfg_kind == 3'(CFG_W64_CTRL)) |=> (int'(size_q) >= MIN_LOG2));

endmodule

// File: rtl/mmio_win_arbiter.sv
// Resolves overlapping window matches: lowest-numbered 64-bit window first,
// then the 32-bit window; a miss yields zero address and partition.
// Assumes match inputs are all derived from the same lookup address.
module mmio_win_arbiter #(
    parameter int ADDR_W  = 48,
    parameter int PART_W  = 8,
    parameter int NUM_W64 = 16
) (
    input  logic                              rst_n,
    input  logic                              clk,
    input  logic [ADDR_W-1:0]                 lk_addr,
    input  logic [NUM_W64-1:0]                hit64,
    input  logic [NUM_W64-1:0][PART_W-1:0]    part64,
    input  logic                              hit32,
    input  logic [ADDR_W-1:0]                 bus32,
    input  logic [PART_W-1:0]                 part32,
    output logic                              any64,
    output logic                              sel_hit,
    output logic [ADDR_W-1:0]                 sel_addr,
    output logic [PART_W-1:0]                 sel_part
);
    logic [NUM_W64-1:0] grant;
    logic [PART_W-1:0]  part64_sel;
    logic               found;

    // Priority pick: the first matching 64-bit window from index 0 upward.
    always_comb begin
        grant      = '0;
        found      = 1'b0;
        part64_sel = '0;
        for (int i = 0; i < NUM_W64; i++) begin
            if (hit64[i] && !found) begin
                grant[i]   = 1'b1;
                found      = 1'b1;
                part64_sel = part64[i];
            end
        end
    end

    // Final choice between the 64-bit winner, the 32-bit window and a miss.
    always_comb begin
        any64 = |hit64;
        if (any64) begin
            sel_hit  = 1'b1;
            sel_addr = lk_addr;
            sel_part = part64_sel;
        end else if (hit32) begin
            sel_hit  = 1'b1;
            sel_addr = bus32;
            sel_part = part32;
        end else begin
            sel_hit  = 1'b0;
            sel_addr = '0;
            sel_part = '0;
        end
    end

    // R9: at most one 64-bit window is granted.
    assert_single_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R9: a granted window always has a match behind it.
    assert_grant_has_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~hit64) == '0));

endmodule

// File: rtl/mmio_outbound_decoder.sv
// Outbound MMIO window decoder top: one 32-bit remapping window, NUM_W64
// pass-through windows, priority resolution and one response register stage.
// Assumes configuration writes and lookups share the clock; a write is seen
// by lookups from the next cycle on.
module mmio_outbound_decoder
    import mmio_dec_pkg::*;
#(
    parameter int ADDR_W       = 48,
    parameter int NUM_W64      = 16,
    parameter int SEG_BITS     = 8,
    parameter int W32_MIN_LOG2 = 28,
    parameter int W32_MAX_LOG2 = 32,
    parameter int W64_MIN_LOG2 = 28
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [2:0]          cfg_kind,
    input  logic [7:0]          cfg_idx,
    input  logic [ADDR_W-1:0]   cfg_data,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                rsp_valid,
    output logic                rsp_hit,
    output logic [ADDR_W-1:0]   rsp_addr,
    output logic [SEG_BITS-1:0] rsp_part
);
    localparam int PART_W = SEG_BITS;
    localparam int IDX_W  = 8;

    logic                           hit32;
    logic [ADDR_W-1:0]              bus32;
    logic [PART_W-1:0]              part32;
    logic [NUM_W64-1:0]             hit64;
    logic [NUM_W64-1:0][PART_W-1:0] part64;
    logic                           any64;
    logic                           sel_hit;
    logic [ADDR_W-1:0]              sel_addr;
    logic [PART_W-1:0]              sel_part;

    mmio_win32_map #(
        .ADDR_W  (ADDR_W),
        .SEG_BITS(SEG_BITS),
        .IDX_W   (IDX_W),
        .MIN_LOG2(W32_MIN_LOG2),
        .MAX_LOG2(W32_MAX_LOG2)
    ) u_w32 (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (cfg_wr),
        .cfg_kind(cfg_kind),
        .cfg_idx (cfg_idx),
        .cfg_data(cfg_data),
        .lk_addr (req_addr),
        .hit     (hit32),
        .bus_addr(bus32),
        .part    (part32)
    );

    for (genvar g = 0; g < NUM_W64; g++) begin : g_w64
        mmio_win64_slot #(
            .ADDR_W  (ADDR_W),
            .SEG_BITS(SEG_BITS),
            .IDX_W   (IDX_W),
            .MIN_LOG2(W64_MIN_LOG2),
            .MAX_LOG2(ADDR_W),
            .SLOT    (g)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_wr  (cfg_wr),
            .cfg_kind(cfg_kind),
            .cfg_idx (cfg_idx),
            .cfg_data(cfg_data),
            .lk_addr (req_addr),
            .hit     (hit64[g]),
            .part    (part64[g])
        );
    end

    mmio_win_arbiter #(
        .ADDR_W (ADDR_W),
        .PART_W (PART_W),
        .NUM_W64(NUM_W64)
    ) u_arb (
        .rst_n   (rst_n),
        .clk     (clk),
        .lk_addr (req_addr),
        .hit64   (hit64),
        .part64  (part64),
        .hit32   (hit32),
        .bus32   (bus32),
        .part32  (part32),
        .any64   (any64),
        .sel_hit (sel_hit),
        .sel_addr(sel_addr),
        .sel_part(sel_part)
    );

    // Response stage: capture the resolved result; idle cycles clear it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_addr  <= '0;
            rsp_part  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && sel_hit;
            rsp_addr  <= req_valid ? sel_addr : '0;
            rsp_part  <= req_valid ? sel_part : '0;
        end
    end

    // R1: a request yields a valid response on the next edge.
    assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R1: an idle cycle yields no response on the next edge.
    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R2: a miss carries zero address and partition.
    assert_miss_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_addr == '0 && rsp_part == '0));

    // R6: a 64-bit match forwards the request address unchanged.
    assert_w64_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && any64) |=> (rsp_hit && rsp_addr == $past(req_addr)));

endmodule

// File: tb/sim_mmio_outbound_decoder.sv
`timescale 1ns/1ps
module sim_mmio_outbound_decoder;
    localparam int AW = 48;
    localparam int VW = AW + 1 + AW + 8;
    localparam int NV = 12;

    // Each entry: {request address, expected hit, expected bus address, expected partition}
    localparam logic [VW-1:0] VEC [NV] = '{
        {48'h0000_8000_0000, 1'b1, 48'hAB00_0000_0000, 8'h5A},  // R3 R4 seg 0
        {48'h0000_9234_5678, 1'b1, 48'hAB00_1234_5678, 8'h7E},  // R3 R4 seg 0x24
        {48'h0000_FFFF_FFFC, 1'b1, 48'hAB00_7FFF_FFFC, 8'hA5},  // R4 last segment
        {48'h0000_C123_4567, 1'b1, 48'h0000_C123_4567, 8'h55},  // R9 64-bit over 32-bit, R7
        {48'h0000_7FFF_FFFF, 1'b0, 48'h0,              8'h00},  // R2 just below
        {48'h0001_8000_0000, 1'b0, 48'h0,              8'h00},  // R3 upper bit differs
        {48'h0010_2345_6789, 1'b1, 48'h0010_2345_6789, 8'h02},  // R8 R9 slot3 over slot7
        {48'h0010_4000_0010, 1'b1, 48'h0010_4000_0010, 8'h11},  // R9 slot1 over slot3
        {48'h001A_B000_0000, 1'b1, 48'h001A_B000_0000, 8'hAB},  // R8 R6
        {48'h0020_0000_1000, 1'b0, 48'h0,              8'h00},  // R10 disabled slot
        {48'h0030_0010_0000, 1'b1, 48'h0030_0010_0000, 8'h01},  // R5 clamped to 28
        {48'h0030_1000_0000, 1'b0, 48'h0,              8'h00}   // R5 R2 outside
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_kind = '0;
    logic [7:0]    cfg_idx = '0;
    logic [AW-1:0] cfg_data = '0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          rsp_valid;
    logic          rsp_hit;
    logic [AW-1:0] rsp_addr;
    logic [7:0]    rsp_part;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mmio_outbound_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_data(cfg_data), .req_valid(req_valid),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_addr(rsp_addr), .rsp_part(rsp_part)
    );

    function automatic logic [AW-1:0] ctrl(input bit en, input bit segm,
                                           input int size, input logic [7:0] part);
        return AW'({part, 6'(size), segm, en});
    endfunction

    task automatic wr(input logic [2:0] kind, input logic [7:0] idx, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_kind = kind; cfg_idx = idx; cfg_data = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic check(input string req, input logic [AW+9:0] act, input logic [AW+9:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual {valid,hit,addr,part}=%h expected %h", req, act, exp);
        end
    endtask

    // Drive one request on a falling edge and check the response a cycle later.
    task automatic lookup(input string req, input logic [AW-1:0] a, input bit eh,
                          input logic [AW-1:0] ea, input logic [7:0] ep);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {rsp_valid, rsp_hit, rsp_addr, rsp_part}, {1'b1, eh, ea, ep});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 R1: reset state has no response and every lookup misses
        check("R1 reset idle", {rsp_valid, rsp_hit, rsp_addr, rsp_part}, '0);
        lookup("R10 reset miss", 48'h0000_8000_0000, 1'b0, '0, 8'h00);

        // R11: configure the 32-bit window and its table
        wr(3'd0, 8'd0, 48'h0000_8123_4567);
        wr(3'd1, 8'd0, ctrl(1'b1, 1'b0, 31, 8'h00));
        wr(3'd2, 8'd0, 48'hAB00_0000_0000);
        for (int i = 0; i < 256; i++) wr(3'd3, 8'(i), AW'(8'(i) ^ 8'h5A));
        // R11: configure the 64-bit windows
        wr(3'd4, 8'd3,  48'h0010_0000_0000); wr(3'd5, 8'd3,  ctrl(1'b1, 1'b1, 36, 8'h00));
        wr(3'd4, 8'd7,  48'h0010_0000_0000); wr(3'd5, 8'd7,  ctrl(1'b1, 1'b0, 30, 8'h77));
        wr(3'd4, 8'd1,  48'h0010_4000_0000); wr(3'd5, 8'd1,  ctrl(1'b1, 1'b0, 28, 8'h11));
        wr(3'd4, 8'd5,  48'h0000_C000_0000); wr(3'd5, 8'd5,  ctrl(1'b1, 1'b0, 28, 8'h55));
        wr(3'd4, 8'd9,  48'h0020_0000_0000); wr(3'd5, 8'd9,  ctrl(1'b0, 1'b0, 30, 8'h99));
        wr(3'd4, 8'd12, 48'h0030_0000_0000); wr(3'd5, 8'd12, ctrl(1'b1, 1'b1, 20, 8'h00));

        for (int v = 0; v < NV; v++) begin
            lookup($sformatf("R2-R10 vector %0d", v), VEC[v][VW-1 -: AW], VEC[v][AW+8],
                   VEC[v][AW+7:8], VEC[v][7:0]);
        end

        // R1: idle cycle gives no response
        @(negedge clk);
        check("R1 idle after request", {rsp_valid, rsp_hit, rsp_addr, rsp_part}, '0);

        // R9 R7: with slot 3 disabled the overlapping slot 7 takes over
        wr(3'd5, 8'd3, ctrl(1'b0, 1'b1, 36, 8'h00));
        lookup("R9 R7 slot7 after disable", 48'h0010_2345_6789, 1'b1, 48'h0010_2345_6789, 8'h77);

        // R5: oversized 32-bit size clamps to 32
        wr(3'd1, 8'd0, ctrl(1'b1, 1'b0, 40, 8'h00));
        lookup("R5 w32 clamp to 32", 48'h0000_0000_1000, 1'b1, 48'hAB00_0000_1000, 8'h5A);
        // R5: undersized 32-bit size clamps to 28
        wr(3'd1, 8'd0, ctrl(1'b1, 1'b0, 20, 8'h00));
        lookup("R5 w32 clamp to 28 hit", 48'h0000_8AB0_0000, 1'b1, 48'hAB00_0AB0_0000, 8'hF1);
        lookup("R5 w32 clamp to 28 miss", 48'h0000_9000_0000, 1'b0, '0, 8'h00);
        // R10: disabling the 32-bit window removes its hits
        wr(3'd1, 8'd0, ctrl(1'b0, 1'b0, 28, 8'h00));
        lookup("R10 w32 disabled", 48'h0000_8AB0_0000, 1'b0, '0, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual still running, expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule